// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is a single-master I2C controller that software runs through two byte-wide registers: a control/status register and a data register. Each transfer begins as a side effect of a register access. Writing the data register in transmit mode shifts that byte onto the bus. Reading it in receive mode returns the byte already held and clocks in the next one. The first read after entering receive mode is therefore a dummy read that only starts the sequence. The first byte written after the bus is taken is the address byte. Software supplies its R/W bit in bit 0, and the hardware sends the byte unchanged.

Both bus lines are open-drain. Each has an output enable, which pulls the line low when high and releases it when low, and a separate input that reads the wired-AND level. SCL runs at a period of 4×DIV system clocks. Each bit is split into four quarter phases of DIV clocks: two with SCL low, then two with SCL high. START, repeated START and STOP use the same quarter sequencer. Out of reset, and whenever it is not master, the controller idles with both lines released.

Top module: `i2c_byte_master`

## Requirements
- R1: With the enable bit (control bit 0) set while idle, the controller issues a START only when SCL and SDA both read high. A START is SDA pulled low while SCL stays released, and the controller then owns the bus (status bit 5 = 1).
- R2: Writing control bit 3 as 1 while the bus is owned produces a repeated START with no STOP before it, and bit 3 reads back as 0 once the repeated START has begun.
- R3: The first data-register write after the bus is taken is sent as the address byte: all 8 bits unchanged, with bit 0 as the R/W bit.
- R4: In transmit mode (control bit 1 = 1), a data-register write while owned and between bytes sends the byte MSB first, with SDA changing only while SCL is low. On the ninth clock SDA is released and its level is stored in status bit 7 (1 = not acknowledged).
- R5: In receive mode (control bit 1 = 0), a data-register read returns the held byte and starts reception of the next byte, so the first read is a dummy read. On the ninth clock the controller drives an ACK (SDA low) unless control bit 2 is set, in which case it leaves SDA released.
- R6: Status bit 6 (byte done) is set at the end of every ninth clock and cleared by any data-register access. If the set and a clear fall in the same cycle, the set wins.
- R7: After reset, the data register is 0x00, the status and control bits are 0, and both lines are released. Both lines stay released whenever the bus is not owned.
- R8: Clearing the enable bit while owned and between bytes produces a STOP (SDA released while SCL is released), after which the controller returns to idle.
- R9: Data-register accesses made while a byte is in flight leave the data register unchanged and start no transfer.
- R10: A byte completes exactly 36×DIV clock cycles after the clock edge that samples the access which starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select: 0 control/status, 1 data |
| regWrEn | input | 1 | Write strobe for the selected register |
| regRdEn | input | 1 | Read strobe (side effects on the data register only) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data: data byte, or {nack, byteDone, owned, 0, restart, noAck, txMode, enable} |
| sclIn | input | 1 | Sensed SCL level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaIn | input | 1 | Sensed SDA level |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
The byte-done flag can be set by the end of the ninth clock and cleared by a data-register access in the same cycle. The bench counts 36×DIV cycles from the edge that samples a transmit-starting write and places a data read exactly on the completing edge. The flag must still read 1 afterwards and must drop only on the following access. That same cycle count also pins down R10: the bench reads the flag one cycle before and one cycle after the completing edge.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HOLD,
    ST_BIT,
    ST_RESTART,
    ST_STOP
  } busState_t;

  // strobes from the sequencer to the byte datapath
  typedef struct packed {
    logic loadTx;      // copy write data into the shifter, byte begins
    logic writeData;   // data register takes write data
    logic shiftOut;    // advance transmit shifter by one bit
    logic sampleIn;    // shift sampled SDA into the shifter
    logic sampleAck;   // store ninth-clock SDA level
    logic byteEnd;     // ninth clock finished
    logic captureRx;   // move received byte to data register
    logic dataAccess;  // any data register access
  } dpStrobe_t;

endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int DIV = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       txBit,
  output logic [3:0] ctrlBits,
  output logic       owned,
  output busState_t  busState,
  output dpStrobe_t  strobe,
  output logic       sclOe,
  output logic       sdaOe
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [3:0] ACK_BIT = 4'd8;

  busState_t state, nextState;
  logic [CW-1:0] divCnt;
  logic [1:0] quarter;
  logic [3:0] bitIdx;
  logic byteTx, masterEn, txMode, noAck, restartReq;
  logic tick, lastQ, dataWr, dataRd, ctrlWr, startTx, startRx;
  logic sclNext, sdaNext, bitDrive;

  assign tick   = (divCnt == LAST);
  assign lastQ  = tick && (quarter == 2'd3);
  assign dataWr = regWrEn && regSel;
  assign dataRd = regRdEn && regSel;
  assign ctrlWr = regWrEn && !regSel;
  assign startTx = (state == ST_HOLD) && masterEn && !restartReq && dataWr && txMode;
  assign startRx = (state == ST_HOLD) && masterEn && !restartReq && dataRd && !txMode;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:    if (masterEn && sclIn && sdaIn) nextState = ST_START;
      ST_START:   if (lastQ) nextState = ST_HOLD;
      ST_RESTART: if (lastQ) nextState = ST_HOLD;
      ST_HOLD: begin
        if (!masterEn)              nextState = ST_STOP;
        else if (restartReq)        nextState = ST_RESTART;
        else if (startTx || startRx) nextState = ST_BIT;
      end
      ST_BIT:  if (lastQ && bitIdx == ACK_BIT) nextState = ST_HOLD;
      ST_STOP: if (lastQ) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      quarter <= '0;
      bitIdx  <= '0;
      byteTx  <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) begin
        divCnt  <= '0;
        quarter <= '0;
        if (nextState == ST_BIT) bitIdx <= '0;
      end else if (state != ST_IDLE && state != ST_HOLD) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) quarter <= quarter + 1'b1;
        if (state == ST_BIT && lastQ) bitIdx <= bitIdx + 1'b1;
      end
      if (startTx) byteTx <= 1'b1;
      else if (startRx) byteTx <= 1'b0;
    end
  end

  // control register; the restart request clears itself once acted on
  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterEn   <= 1'b0;
      txMode     <= 1'b0;
      noAck      <= 1'b0;
      restartReq <= 1'b0;
    end else if (ctrlWr) begin
      masterEn   <= regWrData[0];
      txMode     <= regWrData[1];
      noAck      <= regWrData[2];
      restartReq <= regWrData[3];
    end else if (state == ST_IDLE || nextState == ST_RESTART) begin
      restartReq <= 1'b0;
    end
  end

  // line drive per state and quarter (1 = pull low)
  always_comb begin
    if (bitIdx < ACK_BIT) bitDrive = byteTx ? !txBit : 1'b0;
    else                  bitDrive = byteTx ? 1'b0 : !noAck;
    sclNext = 1'b0;
    sdaNext = sdaOe;
    case (state)
      ST_IDLE:    sdaNext = 1'b0;
      ST_START: begin
        sclNext = (quarter >= 2'd2);
        sdaNext = (quarter >= 2'd1);
      end
      ST_HOLD:    sclNext = 1'b1;
      ST_BIT: begin
        sclNext = (quarter < 2'd2);
        if (quarter != 2'd0) sdaNext = bitDrive;
      end
      ST_RESTART: begin
        sclNext = (quarter == 2'd0);
        sdaNext = (quarter >= 2'd2);
      end
      ST_STOP: begin
        sclNext = (quarter == 2'd0);
        sdaNext = (quarter <= 2'd1);
      end
      default: sdaNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      sclOe <= sclNext;
      sdaOe <= sdaNext;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.loadTx     = startTx;
    strobe.writeData  = dataWr && (state != ST_BIT);
    strobe.shiftOut   = (state == ST_BIT) && byteTx && lastQ && (bitIdx < ACK_BIT);
    strobe.sampleIn   = (state == ST_BIT) && !byteTx && tick && (quarter == 2'd2) && (bitIdx < ACK_BIT);
    strobe.sampleAck  = (state == ST_BIT) && byteTx && tick && (quarter == 2'd2) && (bitIdx == ACK_BIT);
    strobe.byteEnd    = (state == ST_BIT) && lastQ && (bitIdx == ACK_BIT);
    strobe.captureRx  = strobe.byteEnd && !byteTx;
    strobe.dataAccess = dataWr || dataRd;
  end

  assign ctrlBits = {restartReq, noAck, txMode, masterEn};
  assign owned    = (state != ST_IDLE);
  assign busState = state;

endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [7:0] regWrData,
  input  logic       sdaIn,
  output logic [7:0] dataReg,
  output logic       txBit,
  output logic       byteDone,
  output logic       nackSeen
);

  logic [7:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataReg  <= '0;
      byteDone <= 1'b0;
      nackSeen <= 1'b0;
    end else begin
      if (strobe.loadTx)        shiftReg <= regWrData;
      else if (strobe.shiftOut) shiftReg <= {shiftReg[6:0], 1'b0};
      else if (strobe.sampleIn) shiftReg <= {shiftReg[6:0], sdaIn};

      if (strobe.captureRx)      dataReg <= shiftReg;
      else if (strobe.writeData) dataReg <= regWrData;

      // completion has priority over the clearing access
      if (strobe.byteEnd)         byteDone <= 1'b1;
      else if (strobe.dataAccess) byteDone <= 1'b0;

      if (strobe.sampleAck) nackSeen <= sdaIn;
    end
  end

  assign txBit = shiftReg[7];

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int DIV = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sclIn,
  output logic       sclOe,
  input  logic       sdaIn,
  output logic       sdaOe
);

  dpStrobe_t  strobe;
  busState_t  busState;
  logic [3:0] ctrlBits;
  logic [7:0] dataReg;
  logic       owned, txBit, byteDone, nackSeen;

  i2cm_ctrl #(.DIV(DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .sclIn(sclIn), .sdaIn(sdaIn), .txBit(txBit),
    .ctrlBits(ctrlBits), .owned(owned), .busState(busState), .strobe(strobe),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  i2cm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData), .sdaIn(sdaIn),
    .dataReg(dataReg), .txBit(txBit), .byteDone(byteDone), .nackSeen(nackSeen)
  );

  assign regRdData = regSel ? dataReg : {nackSeen, byteDone, owned, 1'b0, ctrlBits};

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
  import i2cm_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       sclIn,
  input logic       sdaIn,
  input logic       owned,
  input logic       byteDone,
  input logic [7:0] dataReg,
  input busState_t  busState,
  input dpStrobe_t  strobe
);

  // R1
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(owned) |-> $past(sclIn && sdaIn));

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !owned |-> (!sclOe && !sdaOe));

  // R4
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_BIT && !$stable(sdaOe)) |-> (sclOe && $past(sclOe)));

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteEnd |=> byteDone);

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataAccess && !strobe.byteEnd) |=> !byteDone);

  // R9
  busy_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_BIT && !strobe.byteEnd) |=> $stable(dataReg));

endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe), .sclIn(sclIn), .sdaIn(sdaIn),
  .owned(owned), .byteDone(byteDone), .dataReg(dataReg), .busState(busState),
  .strobe(strobe)
);

// File: tb/test_i2c_byte_master.sv
`timescale 1ns/1ps
module test_i2c_byte_master;

  localparam int DIV = 2;
  localparam int BYTE_CYC = 36 * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic sclOe, sdaOe, sclLine, sdaLine, slaveDrive;
  logic busHold = 1'b0, slaveTx = 1'b0, slaveAck = 1'b1;
  logic [7:0] rxByte = '0;
  logic [8:0] mon = '0;
  logic [3:0] pos = '0;
  int bitCnt = 0, startCnt = 0, stopCnt = 0;
  int vectors = 0, errors = 0;

  always #2 clk = ~clk;

  assign sclLine = !sclOe;
  assign sdaLine = !(sdaOe || slaveDrive || busHold);
  assign slaveDrive = (pos == 4'd8) ? (!slaveTx && slaveAck)
                                    : (slaveTx && !rxByte[3'(7 - pos)]);

  i2c_byte_master #(.DIV(DIV)) i_i2c_byte_master (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .sclIn(sclLine), .sclOe(sclOe),
    .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  // bus observer and target model
  always @(posedge sclLine) begin
    mon = {mon[7:0], sdaLine};
    bitCnt = bitCnt + 1;
  end
  always @(negedge sclLine) pos = 4'(bitCnt % 9);
  always @(negedge sdaLine) if (sclLine === 1'b1) begin startCnt++; bitCnt = 0; end
  always @(posedge sdaLine) if (sclLine === 1'b1) stopCnt++;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit rd, input bit sel, input logic [7:0] d,
                        output logic [7:0] q);
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regSel = sel; regWrData = d;
    #1 q = regRdData;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0; regSel = 1'b0;
  endtask

  task automatic status(output logic [7:0] q);
    regSel = 1'b0;
    #1 q = regRdData;
  endtask

  task automatic waitDone();
    logic [7:0] s;
    do begin
      @(negedge clk);
      status(s);
    end while (!s[6]);
  endtask

  function automatic logic [7:0] rv(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] q, s;
    int bStart, bStop, bBits;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 sclOe", sclOe, 0);
    check("R7 sdaOe", sdaOe, 0);
    status(s);
    check("R7 status", s, 0);
    access(0, 1, 1, 0, q);
    check("R7 data", q, 0);

    // R1 busy bus blocks START
    busHold = 1'b1;
    access(1, 0, 0, 8'h03, q);
    repeat (20) @(negedge clk);
    status(s);
    check("R1 no start while busy", s[5], 0);
    check("R1 lines released", {sclOe, sdaOe}, 0);
    bStart = startCnt;
    busHold = 1'b0;
    repeat (4 * DIV + 8) @(negedge clk);
    status(s);
    check("R1 owned", s[5], 1);
    check("R1 one start", startCnt - bStart, 1);

    // R3 address byte
    slaveAck = 1'b1;
    access(1, 0, 1, 8'hA4, q);
    waitDone();
    check("R3 address", mon[8:1], 8'hA4);

    // R4 exhaustive transmit sweep
    for (int v = 0; v < 256; v++) begin
      slaveAck = (v % 3) != 0;
      access(1, 0, 1, 8'(v), q);
      waitDone();
      status(s);
      check("R4 tx byte", mon[8:1], v);
      check("R4 nack flag", s[7], slaveAck ? 0 : 1);
    end
    slaveAck = 1'b1;

    // R10 and R6 clear: exact completion cycle
    @(negedge clk); regWrEn = 1; regSel = 1; regWrData = 8'h5A;
    @(negedge clk); regWrEn = 0;
    status(s);
    check("R6 cleared by write", s[6], 0);
    repeat (BYTE_CYC - 1) @(negedge clk);
    status(s);
    check("R10 not done early", s[6], 0);
    @(negedge clk);
    status(s);
    check("R10 done on time", s[6], 1);

    // R6 collision: read on the completing edge, set wins
    @(negedge clk); regWrEn = 1; regSel = 1; regWrData = 8'h96;
    @(negedge clk); regWrEn = 0;
    repeat (BYTE_CYC - 1) @(negedge clk);
    regRdEn = 1; regSel = 1;
    @(negedge clk); regRdEn = 0;
    status(s);
    check("R6 set wins", s[6], 1);
    access(0, 1, 1, 0, q);
    check("R6 data readback", q, 8'h96);
    status(s);
    check("R6 cleared by read", s[6], 0);

    // R9 write during a byte is ignored
    @(negedge clk); regWrEn = 1; regSel = 1; regWrData = 8'hC3;
    @(negedge clk); regWrEn = 0;
    repeat (10) @(negedge clk);
    access(1, 0, 1, 8'h3C, q);
    waitDone();
    check("R9 sent byte", mon[8:1], 8'hC3);
    access(0, 1, 1, 0, q);
    check("R9 data kept", q, 8'hC3);
    bBits = bitCnt;
    repeat (100) @(negedge clk);
    check("R9 no extra transfer", bitCnt, bBits);

    // R2 repeated START
    bStart = startCnt; bStop = stopCnt;
    access(1, 0, 0, 8'h0B, q);
    repeat (4 * DIV + 8) @(negedge clk);
    status(s);
    check("R2 one restart", startCnt - bStart, 1);
    check("R2 no stop", stopCnt - bStop, 0);
    check("R2 bit self-clears", s[3], 0);
    check("R2 still owned", s[5], 1);
    access(1, 0, 1, 8'hA5, q);
    waitDone();
    check("R3 read address", mon[8:1], 8'hA5);

    // R5 receive sweep with dummy read first
    slaveTx = 1'b1;
    rxByte = rv(0);
    access(1, 0, 0, 8'h01, q);
    access(0, 1, 1, 0, q);
    check("R5 dummy read value", q, 8'hA5);
    for (int i = 0; i < 256; i++) begin
      waitDone();
      check("R5 ack level", mon[0], (i == 255) ? 1 : 0);
      if (i < 255) begin
        rxByte = rv(i + 1);
        if (i + 1 == 255) access(1, 0, 0, 8'h05, q);
        access(0, 1, 1, 0, q);
        check("R5 rx byte", q, rv(i));
      end
    end

    // R8 STOP then idle
    slaveTx = 1'b0;
    bStop = stopCnt;
    access(1, 0, 0, 8'h00, q);
    repeat (4 * DIV + 8) @(negedge clk);
    status(s);
    check("R8 stop seen", stopCnt - bStop, 1);
    check("R8 not owned", s[5], 0);
    check("R7 released after stop", {sclOe, sdaOe}, 0);
    access(0, 1, 1, 0, q);
    check("R5 last byte", q, rv(255));
    repeat (20) @(negedge clk);
    check("R7 idle stays released", {sclOe, sdaOe}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule